// File: doc/BRIEF.md
# GPIO Edge-Detect Interrupt Unit

This block watches a wide set of general-purpose pins, organised as equal banks, for level transitions. For every pin it holds a sticky edge flag. A 0-to-1 transition sets the flag when the pin is configured as an input and its rising-edge enable is on. A 1-to-0 transition sets the flag when the pin is an input and its falling-edge enable is on. The pin levels it receives are already synchronised to the clock. The direction and enable masks come from registers that live outside this block.

Software reads the flags one bank at a time through a small bank-addressed port. The same port clears flags: in a write, each 1 bit clears the matching flag. The flags feed three level interrupts. Pin 0 and pin 1 each have their own line, and one shared line covers every other pin. A wake-up pulse is raised when a wake-capable input pin changes level while the processor reports that it is halted.

Top module: `gpio_edge_irq`

## Requirements
- R1: An edge flag becomes 1 at the clock edge that first samples a pin at 1 after it was 0, provided the pin's rising enable is 1 and its direction bit is 0 (0 = input, 1 = output).
- R2: An edge flag becomes 1 at the clock edge that first samples a pin at 0 after it was 1, provided the pin's falling enable is 1 and its direction bit is 0.
- R3: A pin whose direction bit is 1 never sets its flag, whatever its enables and transitions.
- R4: Flags are sticky. A clear write (`clr_we` = 1) to bank `clr_bank` clears each flag whose `clr_data` bit is 1 and leaves the others untouched. `stat_rdata` shows the flags of bank `clr_bank`, where pin p sits in bank p/32 at bit p%32.
- R5: When a new edge and a clear of the same flag happen in the same cycle, the flag stays 1.
- R6: `irq_pin0` and `irq_pin1` are registered copies of the flags of pins 0 and 1, one cycle behind the flags.
- R7: `irq_rest` is a registered OR of the flags of pins 2 and up, one cycle behind the flags.
- R8: Only input pins in the fixed wake masks can wake the processor. The masks are 0x8003FE1B, 0x002001FC, 0xEC080000 and 0x0012007F for banks 0 to 3, with bit n of a mask standing for pin n of that bank.
- R9: `wake_req` is a one-cycle pulse, raised the cycle after a wake-capable pin changes level with `cpu_halted` = 1. It never rises while `cpu_halted` = 0.
- R10: A synchronous active-low reset clears all flags, all stored previous levels and all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_level | input | 128 | Synchronised pin levels |
| pin_is_out | input | 128 | Direction per pin, 1 = output |
| rise_en | input | 128 | Rising-edge enable per pin |
| fall_en | input | 128 | Falling-edge enable per pin |
| cpu_halted | input | 1 | Processor is halted |
| clr_we | input | 1 | Clear strobe for the selected bank |
| clr_bank | input | 2 | Bank selected for readback and clear |
| clr_data | input | 32 | Write-one-to-clear mask |
| stat_rdata | output | 32 | Flags of the selected bank |
| irq_pin0 | output | 1 | Interrupt for pin 0 |
| irq_pin1 | output | 1 | Interrupt for pin 1 |
| irq_rest | output | 1 | Interrupt for all other pins |
| wake_req | output | 1 | One-cycle wake-up pulse |

## Verification
The bench builds the block with its default parameters: four banks of 32 pins and the built-in wake masks. This setting reaches the bank-0 split between the dedicated lines and the shared line, pins in every bank, and wake masks whose set bits are scattered unevenly across all four banks. Sparse random toggling, with random masks, direction bits and clears, mixes with directed cases. These cover output pins, a clear that collides with an edge, and a wake attempt while the processor is running.

// File: rtl/gpio_edge_pkg.sv
`timescale 1ns/1ps
// Package: shared defaults for the GPIO edge-detect unit.
// Assumes banks are packed bank 0 in the least significant bits.
package gpio_edge_pkg;
    localparam int unsigned DEF_BANKS  = 4;
    localparam int unsigned DEF_BANK_W = 32;
    // Wake-capable pins, bank 3 down to bank 0.
    localparam logic [127:0] DEF_WAKE_MASKS = {
        32'h0012007F, 32'hEC080000, 32'h002001FC, 32'h8003FE1B
    };
endpackage

// File: rtl/gpio_edge_bank.sv
`timescale 1ns/1ps
// Module: one bank of per-pin edge detectors with sticky flags.
// Keeps last cycle's level per pin, flags enabled edges on input pins,
// clears flags by mask (a new edge wins), and reports wake-pin changes.
// Assumes lvl is already synchronous to clk.
module gpio_edge_bank #(
    parameter int unsigned W = 32,
    parameter logic [W-1:0] WAKE_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] is_out,
    input  logic [W-1:0] rise_en,
    input  logic [W-1:0] fall_en,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] flags,
    output logic         wake_hit
);
    logic [W-1:0] prev_q;
    logic [W-1:0] flag_q;
    logic [W-1:0] rise_hit;
    logic [W-1:0] fall_hit;
    logic [W-1:0] edge_hit;

    // Edge qualification against the stored level, inputs only.
    always_comb begin
        rise_hit = lvl & ~prev_q & rise_en & ~is_out;
        fall_hit = ~lvl & prev_q & fall_en & ~is_out;
        edge_hit = rise_hit | fall_hit;
        wake_hit = |((lvl ^ prev_q) & ~is_out & WAKE_MASK);
    end

    // Remember each pin's level for next cycle's comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    // Sticky flags: clear by mask, then set by new edges.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~clr_mask) | edge_hit;
    end

    assign flags = flag_q;

    AST_OUT_PIN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag_q & ~$past(flag_q) & $past(is_out)) == '0)); // R3
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag_q & $past(clr_mask & ~edge_hit)) == '0)); // R4
    AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_hit != '0) |=> ((flag_q & $past(edge_hit)) == $past(edge_hit))); // R5
endmodule

// File: rtl/gpio_irq_merge.sv
`timescale 1ns/1ps
// Module: registers the three interrupt levels and the wake pulse.
// Pins 0 and 1 get their own lines; all higher pins share one line.
// Assumes TOTAL >= 3 and that wake_hits is true only on a level change.
module gpio_irq_merge #(
    parameter int unsigned TOTAL = 128,
    parameter int unsigned NB    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TOTAL-1:0] flags_all,
    input  logic [NB-1:0]    wake_hits,
    input  logic             halted,
    output logic             irq0,
    output logic             irq1,
    output logic             irq_other,
    output logic             wake
);
    // Register the interrupt levels from the flag contents.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq0      <= 1'b0;
            irq1      <= 1'b0;
            irq_other <= 1'b0;
        end else begin
            irq0      <= flags_all[0];
            irq1      <= flags_all[1];
            irq_other <= |flags_all[TOTAL-1:2];
        end
    end

    // One-cycle wake pulse when halted and a wake pin moved.
    always_ff @(posedge clk) begin
        if (!rst_n) wake <= 1'b0;
        else        wake <= halted & (|wake_hits);
    end

    AST_IRQ0_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq0 == $past(flags_all[0]))); // R6
    AST_IRQ1_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq1 == $past(flags_all[1]))); // R6
    AST_OTHER_HAS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        irq_other |-> $past(|flags_all[TOTAL-1:2])); // R7
    AST_WAKE_NEEDS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> $past(halted)); // R9
endmodule

// File: rtl/gpio_edge_irq.sv
`timescale 1ns/1ps
// Module: top of the GPIO edge-detect interrupt unit.
// Replicates one detector bank per group of pins, decodes the
// bank-addressed clear port, muxes the readback and merges interrupts.
// Assumes synchronised pin levels and externally held enable masks.
module gpio_edge_irq
    import gpio_edge_pkg::*;
#(
    parameter int unsigned NUM_BANKS = DEF_BANKS,
    parameter int unsigned BANK_W    = DEF_BANK_W,
    parameter logic [NUM_BANKS*BANK_W-1:0] WAKE_MASKS = DEF_WAKE_MASKS,
    localparam int unsigned TOTAL = NUM_BANKS * BANK_W,
    localparam int unsigned SEL_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TOTAL-1:0]  pin_level,
    input  logic [TOTAL-1:0]  pin_is_out,
    input  logic [TOTAL-1:0]  rise_en,
    input  logic [TOTAL-1:0]  fall_en,
    input  logic              cpu_halted,
    input  logic              clr_we,
    input  logic [SEL_W-1:0]  clr_bank,
    input  logic [BANK_W-1:0] clr_data,
    output logic [BANK_W-1:0] stat_rdata,
    output logic              irq_pin0,
    output logic              irq_pin1,
    output logic              irq_rest,
    output logic              wake_req
);
    logic [TOTAL-1:0]     flags_all;
    logic [NUM_BANKS-1:0] wake_hits;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [BANK_W-1:0] clr_mask;

        // Steer the clear mask to the addressed bank only.
        always_comb begin
            clr_mask = (clr_we && (clr_bank == SEL_W'(b))) ? clr_data : '0;
        end

        gpio_edge_bank #(
            .W         (BANK_W),
            .WAKE_MASK (WAKE_MASKS[b*BANK_W +: BANK_W])
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .lvl      (pin_level[b*BANK_W +: BANK_W]),
            .is_out   (pin_is_out[b*BANK_W +: BANK_W]),
            .rise_en  (rise_en[b*BANK_W +: BANK_W]),
            .fall_en  (fall_en[b*BANK_W +: BANK_W]),
            .clr_mask (clr_mask),
            .flags    (flags_all[b*BANK_W +: BANK_W]),
            .wake_hit (wake_hits[b])
        );
    end

    // Readback of the selected bank's flags.
    always_comb begin
        stat_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (clr_bank == SEL_W'(b)) stat_rdata = flags_all[b*BANK_W +: BANK_W];
        end
    end

    gpio_irq_merge #(
        .TOTAL (TOTAL),
        .NB    (NUM_BANKS)
    ) u_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .flags_all (flags_all),
        .wake_hits (wake_hits),
        .halted    (cpu_halted),
        .irq0      (irq_pin0),
        .irq1      (irq_pin1),
        .irq_other (irq_rest),
        .wake      (wake_req)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!irq_pin0 && !irq_pin1 && !irq_rest && !wake_req && flags_all == '0)); // R10
endmodule

// File: tb/sim_gpio_edge_irq.sv
`timescale 1ns/1ps
// Bench: directed corner cases then sparse random toggling, checked
// against a cycle model written from the requirements.
module sim_gpio_edge_irq;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] lvl = '0, dir = '0, re = '0, fe = '0;
    logic         halted = 1'b0, cwe = 1'b0;
    logic [1:0]   cbank = '0;
    logic [31:0]  cdata = '0;
    logic [31:0]  stat_rdata;
    logic         irq_pin0, irq_pin1, irq_rest, wake_req;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // Bench-side model state.
    logic [127:0] m_flag = '0, m_prev = '0;
    logic         m_i0 = 0, m_i1 = 0, m_ir = 0, m_wk = 0;
    localparam logic [127:0] WMASK = {32'h0012007F, 32'hEC080000, 32'h002001FC, 32'h8003FE1B};

    always #2 clk = ~clk;

    gpio_edge_irq u0 (
        .clk(clk), .rst_n(rst_n), .pin_level(lvl), .pin_is_out(dir),
        .rise_en(re), .fall_en(fe), .cpu_halted(halted), .clr_we(cwe),
        .clr_bank(cbank), .clr_data(cdata), .stat_rdata(stat_rdata),
        .irq_pin0(irq_pin0), .irq_pin1(irq_pin1), .irq_rest(irq_rest),
        .wake_req(wake_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] sparse();
        logic [127:0] r;
        r = {$urandom, $urandom, $urandom, $urandom};
        r = r & {$urandom, $urandom, $urandom, $urandom};
        return r & {$urandom, $urandom, $urandom, $urandom};
    endfunction

    // One cycle: inputs already driven at a falling edge, model updated
    // at the rising edge, outputs compared at the next falling edge.
    task automatic step();
        logic [127:0] edges, clrm;
        @(posedge clk);
        clrm  = cwe ? ({96'b0, cdata} << (cbank * 32)) : '0;
        edges = ~dir & ((lvl & ~m_prev & re) | (~lvl & m_prev & fe));
        m_i0  = m_flag[0];
        m_i1  = m_flag[1];
        m_ir  = |m_flag[127:2];
        m_wk  = halted & (|((lvl ^ m_prev) & ~dir & WMASK));
        m_flag = (m_flag & ~clrm) | edges;
        m_prev = lvl;
        @(negedge clk);
        chk("R4 flags", stat_rdata, m_flag[cbank*32 +: 32]);
        chk("R6 irq_pin0", {31'b0, irq_pin0}, {31'b0, m_i0});
        chk("R6 irq_pin1", {31'b0, irq_pin1}, {31'b0, m_i1});
        chk("R7 irq_rest", {31'b0, irq_rest}, {31'b0, m_ir});
        chk("R8 wake_req", {31'b0, wake_req}, {31'b0, m_wk});
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        void'($urandom(32'd7321));
        repeat (4) @(negedge clk);
        // Reset state, R10
        for (int b = 0; b < 4; b++) begin
            cbank = 2'(b);
            #0;
            chk("R10 flags at reset", stat_rdata, 32'h0);
        end
        chk("R10 irqs at reset", {28'b0, irq_pin0, irq_pin1, irq_rest, wake_req}, 32'h0);
        rst_n = 1'b1;
        cbank = 2'd1;
        step();

        // R1: rising edge on input pin 37 (bank 1 bit 5)
        re[37] = 1'b1; fe[37] = 1'b1;
        lvl[37] = 1'b1; step();
        chk("R1 rising sets flag", stat_rdata, 32'h20);
        step();
        chk("R7 shared line high", {31'b0, irq_rest}, 32'h1);
        cwe = 1'b1; cdata = 32'h20; step(); cwe = 1'b0;
        chk("R4 clear by one", stat_rdata, 32'h0);
        // R2: falling edge
        lvl[37] = 1'b0; step();
        chk("R2 falling sets flag", stat_rdata, 32'h20);
        cwe = 1'b1; cdata = 32'h0; step();
        chk("R4 zero leaves flag", stat_rdata, 32'h20);
        cdata = 32'h20; step(); cwe = 1'b0;
        // R3: output pin 40 never flags
        dir[40] = 1'b1; re[40] = 1'b1; fe[40] = 1'b1;
        lvl[40] = 1'b1; step();
        lvl[40] = 1'b0; step();
        chk("R3 output pin silent", stat_rdata, 32'h0);

        // R6 / R5 on pin 0
        cbank = 2'd0; re[0] = 1'b1; fe[0] = 1'b1;
        lvl[0] = 1'b1; step();
        chk("R6 pin0 lags flag", {31'b0, irq_pin0}, 32'h0);
        step();
        chk("R6 pin0 raised", {31'b0, irq_pin0}, 32'h1);
        lvl[0] = 1'b0; cwe = 1'b1; cdata = 32'h1; step();
        chk("R5 edge beats clear", stat_rdata[0], 1'b1);
        step(); cwe = 1'b0;
        chk("R4 later clear", stat_rdata[0], 1'b0);
        re[1] = 1'b1; lvl[1] = 1'b1; step(); step();
        chk("R6 pin1 raised", {31'b0, irq_pin1}, 32'h1);

        // R9 / R8 wake behaviour
        halted = 1'b0; lvl[0] = 1'b1; step();
        chk("R9 no wake while running", {31'b0, wake_req}, 32'h0);
        halted = 1'b1; lvl[0] = 1'b0; step();
        chk("R8 wake pin toggles", {31'b0, wake_req}, 32'h1);
        step();
        chk("R9 wake is a pulse", {31'b0, wake_req}, 32'h0);
        lvl[2] = 1'b1; step();
        chk("R8 non-wake pin", {31'b0, wake_req}, 32'h0);
        lvl[83] = 1'b1; step();
        chk("R8 bank2 wake pin", {31'b0, wake_req}, 32'h1);
        dir[83] = 1'b1; lvl[83] = 1'b0; step();
        chk("R8 output wake pin", {31'b0, wake_req}, 32'h0);

        // Random phase
        for (int i = 0; i < 6000; i++) begin
            lvl = lvl ^ sparse();
            if ($urandom_range(15) == 0) dir = sparse();
            if ($urandom_range(7) == 0) re = {$urandom, $urandom, $urandom, $urandom};
            if ($urandom_range(7) == 0) fe = {$urandom, $urandom, $urandom, $urandom};
            halted = ($urandom_range(3) != 0);
            cwe    = ($urandom_range(2) == 0);
            cbank  = 2'($urandom_range(3));
            cdata  = ($urandom_range(1) == 0) ? $urandom : ($urandom & $urandom);
            step();
        end
        report();
    end
endmodule